// File: doc/BRIEF.md
# Paged Buffer Column Mapper

This block sits between a sequential host-side data path and an internal page buffer that holds one NAND page as four 512-byte main areas plus four 16-byte spare areas. The host sees the page as one linear run of byte columns: the main bytes first, then the spare bytes. The block keeps a saved column and turns it into a physical byte address. The main region occupies physical bytes 0x000 to 0x7FF, in areas of 0x200 bytes. The spare region starts at 0x800 and its areas follow each other every 0x10 bytes without gaps. Every access moves the saved column forward by the number of bytes it moved.

Three access widths share the saved column. A byte port reads or writes one byte. A half port reads two consecutive bytes. A word port reads or writes one to four bytes within the addressed 32-bit word and merges them into the byte lanes of that word. The page-size mode selects a 512-byte page with 16 spare bytes or a 2048-byte page with 64 spare bytes. A spare-only mode, applied when a column is loaded, moves a main-range column into the spare range. Accesses stop at the end of the page plus its spare bytes.

Top module: `pbm_page_mapper`

## Requirements
- R1: After reset the saved column `col_o` is 0 and `rd_valid_o` is low.
- R2: With P the page size (512 when `large_page_i`=0, 2048 when 1), a column c below P addresses physical byte c. A column at or above P addresses physical byte 0x800 + (c − P). Both modes share one physical store, so the same physical byte is reachable from either mode.
- R3: A load with `spare_only_i`=1 and a value below P stores value + P as the column. A value at or above P is stored unchanged, and a load with `spare_only_i`=0 stores the value unchanged.
- R4: Bytes are little-endian inside a 32-bit word: column mod 4 = k selects bits 8k+7:8k. Read data returns the first accessed byte in bits 7:0, the next one in bits 15:8 and so on, and zeros above the last byte.
- R5: A word-port write of L bytes (`word_len_i` = L−1) at lane k writes n = min(L, 4−k, bytes left to the end) bytes from `word_wdata_i` bits 7:0 upward into lanes k and above. The other lanes of that word keep their contents.
- R6: A half read returns the bytes at columns c and c+1, even when they lie in different words or c+1 crosses from the main range into the spare range. It advances the column by 2, or by 1 when only one byte is left.
- R7: The end is P + P/32 (528 or 2112). While the column is at or past the end, no access is performed: writes are dropped, `rd_valid_o` stays low and the column holds.
- R8: A performed access advances the column by its byte count: 1 for the byte port, n for the word port.
- R9: A read and a write in the same cycle at the same column (byte port or word port) return the data held before the write, and the write still takes effect.
- R10: Priority per cycle: a column load first, then the word port, then the half port, then the byte port. A lower-priority request in the same cycle is dropped.
- R11: Read data appears on `rd_data_o` with `rd_valid_o` high in the cycle after the request. `rd_valid_o` is low in every cycle after a cycle without a performed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| large_page_i | input | 1 | 0: 512+16 byte page, 1: 2048+64 byte page |
| spare_only_i | input | 1 | Spare-only offset applied at column load |
| col_load_i | input | 1 | Load the saved column |
| col_value_i | input | 13 | Column value to load |
| byte_rd_i | input | 1 | Read one byte |
| byte_wr_i | input | 1 | Write one byte |
| byte_wdata_i | input | 8 | Byte write data |
| half_rd_i | input | 1 | Read two bytes |
| word_rd_i | input | 1 | Word-port read |
| word_wr_i | input | 1 | Word-port write with lane merge |
| word_len_i | input | 2 | Word-port byte count minus one |
| word_wdata_i | input | 32 | Word-port write data, first byte in bits 7:0 |
| col_o | output | 13 | Saved column |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 32 | Read data, first byte in bits 7:0 |

## Verification
The hardest cases to reach from the ports are the seams between areas. One is a half read that starts at the last main byte and finishes in the first spare byte. Another is a word access clipped by both its lane position and the end of the spare range. The third is data that must be seen through both page-size modes, which only shows up when the mode changes between a write and a read. Directed sequences load columns just below each seam and switch modes between a write and its read-back. The random phase weights column loads toward the page and end boundaries, toggles the mode now and then, and mixes every port so that these seams recur many times.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_BYTE,
    ACC_HALF,
    ACC_WORD
  } acc_kind_e;

  typedef logic [15:0] pcol_t;

  // linear column -> physical byte: main bytes pass through, spare bytes
  // are rebased onto the spare region
  function automatic pcol_t col_to_phys(pcol_t col, pcol_t page, pcol_t spare_base);
    return (col < page) ? col : pcol_t'(spare_base + (col - page));
  endfunction

  function automatic logic [2:0] min3(logic [2:0] a, logic [2:0] b, logic [2:0] c);
    logic [2:0] m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  // n consecutive byte enables starting at lane
  function automatic logic [3:0] lane_enables(logic [1:0] lane, logic [2:0] n);
    logic [7:0] run;
    run = (8'd1 << n) - 8'd1;
    run = run << lane;
    return run[3:0];
  endfunction

  function automatic logic [31:0] byte_mask(logic [2:0] n);
    logic [31:0] m;
    for (int j = 0; j < 4; j++) m[8*j +: 8] = (j < int'(n)) ? 8'hFF : 8'h00;
    return m;
  endfunction

endpackage

// File: rtl/pbm_col_ctrl.sv
module pbm_col_ctrl #(
  parameter int COL_W       = 13,
  parameter int BIG_PAGE    = 2048,
  parameter int BIG_SPARE   = 64,
  parameter int SMALL_PAGE  = 512,
  parameter int SMALL_SPARE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             large_page,
  input  logic             spare_only,
  input  logic             load,
  input  logic [COL_W-1:0] load_col,
  input  logic             adv,
  input  logic [2:0]       adv_n,
  output logic [COL_W-1:0] col_q,
  output logic [COL_W-1:0] page_sz,
  output logic [COL_W-1:0] limit,
  output logic             in_range
);

  logic [COL_W-1:0] load_target;

  assign page_sz  = large_page ? COL_W'(BIG_PAGE) : COL_W'(SMALL_PAGE);
  assign limit    = large_page ? COL_W'(BIG_PAGE + BIG_SPARE)
                               : COL_W'(SMALL_PAGE + SMALL_SPARE);
  assign in_range = (col_q < limit);

  assign load_target = (spare_only && (load_col < page_sz)) ? (load_col + page_sz) : load_col;

  always_ff @(posedge clk) begin
    if (!rst_n)     col_q <= '0;
    else if (load)  col_q <= load_target;
    else if (adv)   col_q <= col_q + COL_W'(adv_n);
  end

  AST_COL_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (col_q <= $past(limit)));  // R7

  AST_HOLD_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !in_range) |=> $stable(col_q));  // R7

  AST_SPARE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && spare_only && (load_col < page_sz)) |=> (col_q >= $past(page_sz)));  // R3

endmodule

// File: rtl/pbm_lane_merge.sv
module pbm_lane_merge (
  input  logic [1:0]  lane,
  input  logic [2:0]  n,
  input  logic [31:0] wdata_raw,
  input  logic [31:0] word_a,
  input  logic [31:0] word_b,
  output logic [3:0]  be,
  output logic [31:0] wdata_lanes,
  output logic [31:0] rdata
);
  import pbm_pkg::*;

  logic [63:0] pair;
  logic [63:0] pair_sh;

  assign be          = lane_enables(lane, n);
  assign wdata_lanes = wdata_raw << {lane, 3'b000};

  // word_b only contributes when the run leaves word_a (lane 3, two bytes)
  assign pair    = {word_b, word_a};
  assign pair_sh = pair >> {lane, 3'b000};
  assign rdata   = pair_sh[31:0] & byte_mask(n);

endmodule

// File: rtl/pbm_store.sv
module pbm_store #(
  parameter int WORDS = 528,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [3:0]    be,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [31:0]   rdata_a,
  output logic [31:0]   rdata_b
);

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] bank [WORDS];

    always_ff @(posedge clk) begin
      if (we && be[g]) bank[waddr] <= wdata[8*g +: 8];
    end

    assign rdata_a[8*g +: 8] = bank[raddr_a];
    assign rdata_b[8*g +: 8] = bank[raddr_b];
  end

endmodule

// File: rtl/pbm_page_mapper.sv
module pbm_page_mapper #(
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int AREAS       = 4,
  localparam int COL_W      = $clog2(2 * MAIN_BYTES * AREAS + SPARE_BYTES * AREAS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             large_page_i,
  input  logic             spare_only_i,
  input  logic             col_load_i,
  input  logic [COL_W-1:0] col_value_i,
  input  logic             byte_rd_i,
  input  logic             byte_wr_i,
  input  logic [7:0]       byte_wdata_i,
  input  logic             half_rd_i,
  input  logic             word_rd_i,
  input  logic             word_wr_i,
  input  logic [1:0]       word_len_i,
  input  logic [31:0]      word_wdata_i,
  output logic [COL_W-1:0] col_o,
  output logic             rd_valid_o,
  output logic [31:0]      rd_data_o
);
  import pbm_pkg::*;

  localparam int BIG_PAGE   = MAIN_BYTES * AREAS;
  localparam int BIG_SPARE  = SPARE_BYTES * AREAS;
  localparam int SPARE_BASE = BIG_PAGE;
  localparam int PHYS_BYTES = BIG_PAGE + BIG_SPARE;
  localparam int WORDS      = PHYS_BYTES / 4;
  localparam int AW         = $clog2(WORDS);

  // column state
  logic [COL_W-1:0] col_q, page_sz, limit, room;
  logic             in_range;
  logic [1:0]       lane;
  logic [2:0]       room_cap;

  // access decode
  acc_kind_e   kind;
  logic        acc_rd, acc_wr, perf, rd_fire, wr_fire;
  logic [2:0]  n;
  logic [31:0] wdata_raw;

  // datapath
  pcol_t         phys_a, phys_b;
  logic [AW-1:0] waddr_a, raddr_b;
  logic [3:0]    be;
  logic [31:0]   wdata_lanes, word_a, word_b, rdata_c;
  logic [31:0]   rd_data_q;
  logic          rd_valid_q;

  pbm_col_ctrl #(
    .COL_W(COL_W), .BIG_PAGE(BIG_PAGE), .BIG_SPARE(BIG_SPARE),
    .SMALL_PAGE(MAIN_BYTES), .SMALL_SPARE(SPARE_BYTES)
  ) u_col (
    .clk(clk), .rst_n(rst_n), .large_page(large_page_i), .spare_only(spare_only_i),
    .load(col_load_i), .load_col(col_value_i), .adv(perf), .adv_n(n),
    .col_q(col_q), .page_sz(page_sz), .limit(limit), .in_range(in_range)
  );

  assign lane     = col_q[1:0];
  assign room     = limit - col_q;
  assign room_cap = (room >= COL_W'(4)) ? 3'd4 : room[2:0];

  always_comb begin
    kind   = ACC_NONE;
    acc_rd = 1'b0;
    acc_wr = 1'b0;
    n      = 3'd0;
    if (!col_load_i) begin
      if (word_rd_i || word_wr_i) begin
        kind   = ACC_WORD;
        acc_rd = word_rd_i;
        acc_wr = word_wr_i;
        n      = min3({1'b0, word_len_i} + 3'd1, 3'd4 - {1'b0, lane}, room_cap);
      end else if (half_rd_i) begin
        kind   = ACC_HALF;
        acc_rd = 1'b1;
        n      = min3(3'd2, 3'd4, room_cap);
      end else if (byte_rd_i || byte_wr_i) begin
        kind   = ACC_BYTE;
        acc_rd = byte_rd_i;
        acc_wr = byte_wr_i;
        n      = 3'd1;
      end
    end
  end

  assign perf    = (kind != ACC_NONE) && in_range;
  assign rd_fire = perf && acc_rd;
  assign wr_fire = perf && acc_wr;

  assign wdata_raw = (kind == ACC_WORD) ? word_wdata_i : {24'd0, byte_wdata_i};

  // physical addresses of the current byte and of the byte after it
  assign phys_a  = col_to_phys(pcol_t'(col_q), pcol_t'(page_sz), pcol_t'(SPARE_BASE));
  assign phys_b  = col_to_phys(pcol_t'(col_q) + pcol_t'(1), pcol_t'(page_sz), pcol_t'(SPARE_BASE));
  assign waddr_a = AW'(phys_a >> 2);
  assign raddr_b = ((phys_b >> 2) < pcol_t'(WORDS)) ? AW'(phys_b >> 2) : '0;

  pbm_lane_merge u_merge (
    .lane(lane), .n(n), .wdata_raw(wdata_raw), .word_a(word_a), .word_b(word_b),
    .be(be), .wdata_lanes(wdata_lanes), .rdata(rdata_c)
  );

  pbm_store #(.WORDS(WORDS), .AW(AW)) u_store (
    .clk(clk), .we(wr_fire), .waddr(waddr_a), .be(be), .wdata(wdata_lanes),
    .raddr_a(waddr_a), .raddr_b(raddr_b), .rdata_a(word_a), .rdata_b(word_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_fire;
      if (rd_fire) rd_data_q <= rdata_c;
    end
  end

  assign col_o      = col_q;
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> ($countones(be) == int'(n)));  // R5

  AST_BE_FIRST_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> be[lane]);  // R4

  AST_WADDR_IN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    perf |-> (int'(waddr_a) < WORDS));  // R2

  AST_COL_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    perf |=> (col_o != $past(col_o)));  // R8

endmodule

// File: tb/tb_pbm_page_mapper.sv
module tb_pbm_page_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W      = 13;
  localparam int BIGP       = 2048;
  localparam int SMLP       = 512;
  localparam int SPB        = 2048;
  localparam int PHYS       = 2112;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             large_page_i = 1'b1, spare_only_i = 1'b0, col_load_i = 1'b0;
  logic [COL_W-1:0] col_value_i = '0;
  logic             byte_rd_i = 1'b0, byte_wr_i = 1'b0, half_rd_i = 1'b0;
  logic [7:0]       byte_wdata_i = '0;
  logic             word_rd_i = 1'b0, word_wr_i = 1'b0;
  logic [1:0]       word_len_i = '0;
  logic [31:0]      word_wdata_i = '0;
  logic [COL_W-1:0] col_o;
  logic             rd_valid_o;
  logic [31:0]      rd_data_o;

  pbm_page_mapper dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int  checks = 0, fails = 0;
  bit  finished = 1'b0;
  logic [7:0] mdl [PHYS];
  int  mcol = 0;
  bit  big = 1'b1;

  function automatic int pg_of();   return big ? BIGP : SMLP; endfunction
  function automatic int end_of();  return big ? BIGP + 64 : SMLP + 16; endfunction
  function automatic int phys_of(int c);
    if (c >= pg_of()) return SPB + (c - pg_of());
    return c;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    col_load_i = 0; spare_only_i = 0; byte_rd_i = 0; byte_wr_i = 0;
    half_rd_i = 0; word_rd_i = 0; word_wr_i = 0;
  endtask

  task automatic set_mode(bit b);
    big = b; large_page_i = b;
  endtask

  task automatic do_load(int val, bit so, string tag);
    col_load_i = 1; col_value_i = COL_W'(val); spare_only_i = so;
    @(negedge clk);
    clear_in();
    mcol = (so && val < pg_of()) ? val + pg_of() : val;
    chk(tag, 32'(col_o), 32'(mcol));
    chk(tag, 32'(rd_valid_o), 32'd0);
  endtask

  // kind: 0 byte, 1 half, 2 word
  task automatic do_acc(int kind, bit rd, bit wr, int len, logic [31:0] wd, string tag);
    int n, room, lane;
    bit ok;
    logic [31:0] exp;
    ok   = (mcol < end_of());
    room = end_of() - mcol;
    lane = mcol % 4;
    n = 1;
    if (kind == 1) n = (room < 2) ? room : 2;
    if (kind == 2) begin
      n = len;
      if (4 - lane < n) n = 4 - lane;
      if (room < n) n = room;
    end
    if (kind == 1) begin rd = 1; wr = 0; end
    exp = '0;
    if (ok) for (int j = 0; j < n; j++) exp[8*j +: 8] = mdl[phys_of(mcol + j)];
    case (kind)
      0: begin byte_rd_i = rd; byte_wr_i = wr; byte_wdata_i = wd[7:0]; end
      1: half_rd_i = 1;
      default: begin word_rd_i = rd; word_wr_i = wr; word_len_i = 2'(len - 1); word_wdata_i = wd; end
    endcase
    @(negedge clk);
    clear_in();
    if (ok) begin
      if (wr) for (int j = 0; j < n; j++) mdl[phys_of(mcol + j)] = wd[8*j +: 8];
      mcol += n;
    end
    chk(tag, 32'(rd_valid_o), 32'(ok && rd));
    if (ok && rd) chk(tag, rd_data_o, exp);
    chk(tag, 32'(col_o), 32'(mcol));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R8 watchdog act=running exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", 32'(col_o), 32'd0);
    chk("R1", 32'(rd_valid_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 32'(col_o), 32'd0);

    // prefill the whole store through the word port, large pages
    set_mode(1);
    do_load(0, 0, "R8");
    for (int i = 0; i < PHYS / 4; i++) do_acc(2, 0, 1, 4, $urandom, "R8");
    chk("R7", 32'(col_o), 32'd2112);

    // R2: small-page spare byte aliases large-page spare byte
    set_mode(0);
    do_load(512, 0, "R2");
    do_acc(0, 0, 1, 1, 32'hA5, "R2");
    set_mode(1);
    do_load(2048, 0, "R2");
    do_acc(0, 1, 0, 1, 0, "R2");
    chk("R2", rd_data_o, 32'hA5);
    do_load(512, 0, "R2");               // main area 1 in large mode
    do_acc(0, 1, 0, 1, 0, "R2");

    // R3: spare-only offset
    set_mode(0);
    do_load(3, 1, "R3");
    chk("R3", 32'(col_o), 32'd515);
    set_mode(1);
    do_load(5, 1, "R3");
    chk("R3", 32'(col_o), 32'd2053);
    do_load(2050, 1, "R3");
    chk("R3", 32'(col_o), 32'd2050);

    // R4: little-endian lanes
    do_load(8, 0, "R4");
    do_acc(0, 0, 1, 1, 32'h11, "R4");
    do_acc(0, 0, 1, 1, 32'h22, "R4");
    do_acc(0, 0, 1, 1, 32'h33, "R4");
    do_acc(0, 0, 1, 1, 32'h44, "R4");
    do_load(8, 0, "R4");
    do_acc(2, 1, 0, 4, 0, "R4");
    chk("R4", rd_data_o, 32'h44332211);

    // R5: partial write keeps other lanes
    do_load(9, 0, "R5");
    do_acc(2, 0, 1, 2, 32'h0000BBAA, "R5");
    do_load(8, 0, "R5");
    do_acc(2, 1, 0, 4, 0, "R5");
    chk("R5", rd_data_o, 32'h44BBAA11);
    do_load(14, 0, "R5");
    do_acc(2, 0, 1, 4, 32'hDDCCBBAA, "R5");   // clipped to 2 bytes by lane
    chk("R5", 32'(col_o), 32'd16);

    // R6: half read across words and across main/spare seam
    do_load(11, 0, "R6");
    do_acc(1, 1, 0, 2, 0, "R6");
    do_load(2047, 0, "R6");
    do_acc(1, 1, 0, 2, 0, "R6");
    set_mode(0);
    do_load(511, 0, "R6");
    do_acc(1, 1, 0, 2, 0, "R6");
    do_load(527, 0, "R6");
    do_acc(1, 1, 0, 2, 0, "R6");
    chk("R6", 32'(col_o), 32'd528);

    // R7: end of page plus spare
    set_mode(1);
    do_load(2110, 0, "R7");
    do_acc(2, 1, 0, 4, 0, "R7");
    do_acc(0, 0, 1, 1, 32'h5A, "R7");
    do_acc(0, 1, 0, 1, 0, "R7");
    do_acc(1, 1, 0, 2, 0, "R7");
    do_load(2111, 0, "R7");
    do_acc(0, 1, 0, 1, 0, "R7");

    // R9: same-cycle read and write
    do_load(40, 0, "R9");
    do_acc(0, 1, 1, 1, 32'h77, "R9");
    do_load(40, 0, "R9");
    do_acc(2, 1, 1, 4, 32'hCAFEF00D, "R9");
    do_load(40, 0, "R9");
    do_acc(2, 1, 0, 4, 0, "R9");
    chk("R9", rd_data_o, 32'hCAFEF00D);

    // R10: priorities
    do_load(60, 0, "R10");
    byte_wr_i = 1; byte_wdata_i = 8'hEE;
    do_load(100, 0, "R10");
    do_load(60, 0, "R10");
    do_acc(0, 1, 0, 1, 0, "R10");
    do_load(64, 0, "R10");
    byte_wr_i = 1; byte_wdata_i = 8'h99;
    do_acc(2, 0, 1, 1, 32'h12, "R10");
    byte_wr_i = 1; byte_wdata_i = 8'h98;
    do_acc(1, 1, 0, 2, 0, "R10");
    do_load(64, 0, "R10");
    do_acc(2, 1, 0, 4, 0, "R10");

    // R11: one-cycle latency, valid drops when idle
    do_load(20, 0, "R11");
    do_acc(0, 1, 0, 1, 0, "R11");
    @(negedge clk);
    chk("R11", 32'(rd_valid_o), 32'd0);

    // random phase
    for (int it = 0; it < 4000; it++) begin
      int r, k;
      r = $urandom_range(0, 99);
      if (r < 8) begin
        int v;
        case ($urandom_range(0, 3))
          0: v = pg_of() - 1 - $urandom_range(0, 3);
          1: v = end_of() - 1 - $urandom_range(0, 4);
          2: v = end_of() + $urandom_range(0, 3);
          default: v = $urandom_range(0, end_of() - 1);
        endcase
        do_load(v, 1'($urandom_range(0, 1)), "R3");
      end else if (r < 11) begin
        set_mode(~big);
      end else begin
        bit rd, wr;
        k  = $urandom_range(0, 2);
        rd = 1'($urandom_range(0, 1));
        wr = ~rd | 1'($urandom_range(0, 1));
        do_acc(k, rd, wr, $urandom_range(1, 4), $urandom, "R8");
      end
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule